// File: doc/BRIEF.md
# SGRAM Command Sequencer

This controller sits between a single-request host port and a two-bank synchronous graphics DRAM with a 32-bit data word. After reset it waits out a power-up interval. It then precharges both banks, issues two auto-refresh cycles and programs the mode register. Once that sequence is done it serves host requests one at a time. Each request becomes an activate followed by a single-beat read or write. The column command always carries the auto-precharge flag, so the row closes by itself and every access starts from closed banks.

Host requests use a valid/ready handshake. A request transfers on a rising edge where both `req_valid` and `req_ready` are high. While `req_ready` is low the host must hold the request stable. Read results come back on `rsp_valid`/`rsp_data`, in request order, without back-pressure: the memory cannot be stalled, so the host must take each one-cycle pulse. A refresh timer raises a pending flag at a fixed interval. That flag wins over a waiting host request as soon as the current access has finished. All waits between commands are parameters counted in clocks.

Top module: `sgc_top`

## Requirements
- R1: While reset is applied and until the first command, the pins show NOP, and `req_ready`, `rsp_valid` and `mem_dq_oe` are low. Commands are coded on {cs_n, ras_n, cas_n, we_n, dsf}: NOP 01110, mode set 00000, activate 00110, read 01010, write 01000, precharge 00100, refresh 00010.
- R2: After INIT_WAIT clocks the block issues these commands in order, and no activate comes before them:
  - a precharge with `mem_addr[8]` high;
  - a refresh at least T_RP clocks later;
  - a second refresh at least T_RFC clocks later;
  - a mode set at least T_RFC clocks later, with CAS latency in `mem_addr[6:4]` and all other bits zero (burst of one, sequential order).
  `req_ready` stays low until after the mode set. The first activate comes at least T_MRD clocks after it.
- R3: `req_ready` is high only when the block is idle and no refresh is pending. On the clock after an accepting edge the pins show activate, with `mem_ba` equal to the bank and `mem_addr` equal to the row.
- R4: The read or write command follows its activate after exactly T_RCD clocks, to the same bank. `mem_addr[7:0]` carries the column and `mem_addr[8]` is high (auto precharge).
- R5: No activate or refresh is issued within T_CLOSE clocks after a read or write command.
- R6: In the write command cycle, `mem_dq_oe` is high, `mem_dq_out` carries the write data and `mem_dqm` carries the host mask. A mask bit i of 1 leaves byte i (bits 8i+7:8i) of the stored word unchanged. `mem_dq_oe` is low in every other cycle.
- R7: `rsp_valid` pulses for one cycle per read. It carries the `mem_dq_in` value present at the rising edge CAS_LAT clocks after the edge on which the memory sees the read. Responses come in request order.
- R8: A refresh becomes pending every REF_INTERVAL clocks. It is served before a waiting request once the current access ends, so successive operational refreshes are at most REF_INTERVAL+T_RCD+T_CLOSE+4 clocks apart. Nothing follows a refresh within T_RFC clocks.
- R9: `mem_dsf` is low on every cycle, and no pin combination other than the seven in R1 ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | Bank of the access |
| req_row | input | 10 | Row of the access |
| req_col | input | 8 | Column of the access |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Byte skip mask for writes, 1 = keep byte |
| rsp_valid | output | 1 | Read data strobe |
| rsp_data | output | 32 | Read data |
| mem_cs_n | output | 1 | Chip select, low active |
| mem_ras_n | output | 1 | Row strobe |
| mem_cas_n | output | 1 | Column strobe |
| mem_we_n | output | 1 | Write enable |
| mem_dsf | output | 1 | Special function select, held low |
| mem_addr | output | 10 | Multiplexed row/column address |
| mem_ba | output | 1 | Bank select |
| mem_dqm | output | 4 | Byte masks |
| mem_dq_out | output | 32 | Data toward memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 32 | Data from memory |

## Verification
A wrong wait count shows up on the first access after the mode set. It appears as a column command that is not exactly T_RCD clocks after its activate, or as a command that breaks a minimum gap. A read pipe of the wrong depth returns the word from a neighbouring cycle, so the very first read-back differs from the written data. A lost or stuck refresh flag shows up within one refresh interval: either the gap between refreshes is too long, or refreshes repeat back to back and the host is starved. A wrong byte mask or address field corrupts memory contents, and the corruption is seen on the next read of that word.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  // Pin code {cs_n, ras_n, cas_n, we_n, dsf}
  typedef enum logic [4:0] {
    CMD_MRS = 5'b00000,
    CMD_REF = 5'b00010,
    CMD_PRE = 5'b00100,
    CMD_ACT = 5'b00110,
    CMD_WR  = 5'b01000,
    CMD_RD  = 5'b01010,
    CMD_NOP = 5'b01110
  } cmd_e;

  typedef enum logic [3:0] {
    ST_POWERUP,
    ST_PREALL,
    ST_INITREF0,
    ST_INITREF1,
    ST_LOADMODE,
    ST_IDLE,
    ST_COLUMN,
    ST_WAIT
  } state_e;
endpackage

// File: rtl/sgc_refresh_timer.sv
module sgc_refresh_timer #(
  parameter int INTERVAL = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic served,
  output logic pending
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == CW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      cnt_q   <= tick ? '0 : cnt_q + 1'b1;
      pending <= tick | (pending & ~served);
    end
  end
endmodule

// File: rtl/sgc_read_pipe.sv
module sgc_read_pipe #(
  parameter int CAS_LAT = 3,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  // One stage for the command register, CAS_LAT stages for the device
  logic [CAS_LAT:0] flight_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flight_q  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      flight_q  <= {flight_q[CAS_LAT-1:0], launch};
      rsp_valid <= flight_q[CAS_LAT];
      if (flight_q[CAS_LAT]) rsp_data <= dq_in;
    end
  end
endmodule

// File: rtl/sgc_top.sv
module sgc_top
  import sgc_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 32,
  parameter int CAS_LAT      = 3,
  parameter int INIT_WAIT    = 12500,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 9,
  parameter int T_MRD        = 2,
  parameter int T_CLOSE      = 6,
  parameter int REF_INTERVAL = 1950
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_we,
  input  logic                req_bank,
  input  logic [ADDR_W-1:0]   req_row,
  input  logic [COL_W-1:0]    req_col,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                mem_cs_n,
  output logic                mem_ras_n,
  output logic                mem_cas_n,
  output logic                mem_we_n,
  output logic                mem_dsf,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_ba,
  output logic [DATA_W/8-1:0] mem_dqm,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_in
);
  localparam int BYTES   = DATA_W / 8;
  localparam int AP_BIT  = COL_W;
  localparam int LONGEST = INIT_WAIT + T_RCD + T_RP + T_RFC + T_MRD + T_CLOSE;
  localparam int WAIT_W  = $clog2(LONGEST + 1);
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(CAS_LAT << 4);

  typedef struct packed {
    logic              we;
    logic              bank;
    logic [ADDR_W-1:0] row;
    logic [COL_W-1:0]  col;
    logic [DATA_W-1:0] wdata;
    logic [BYTES-1:0]  mask;
  } host_req_t;

  state_e            state_q, state_d, ret_q, ret_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d;
  host_req_t         held_q;
  cmd_e              cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ba_q, ba_d;
  logic [BYTES-1:0]  dqm_q, dqm_d;
  logic [DATA_W-1:0] dq_q, dq_d;
  logic              oe_q, oe_d;
  logic              take, ref_served, ref_pending;

  sgc_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_refresh (
    .clk     (clk),
    .rst_n   (rst_n),
    .served  (ref_served),
    .pending (ref_pending)
  );

  sgc_read_pipe #(.CAS_LAT(CAS_LAT), .DATA_W(DATA_W)) u_rdpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (cmd_d == CMD_RD),
    .dq_in     (mem_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign req_ready = (state_q == ST_IDLE) && !ref_pending;
  assign take      = req_ready && req_valid;

  always_comb begin
    state_d    = state_q;
    ret_d      = ret_q;
    wcnt_d     = (wcnt_q != '0) ? wcnt_q - 1'b1 : wcnt_q;
    cmd_d      = CMD_NOP;
    addr_d     = '0;
    ba_d       = 1'b0;
    dqm_d      = '0;
    dq_d       = '0;
    oe_d       = 1'b0;
    ref_served = 1'b0;
    unique case (state_q)
      ST_POWERUP: if (wcnt_q == '0) state_d = ST_PREALL;
      ST_PREALL: begin
        cmd_d          = CMD_PRE;
        addr_d[AP_BIT] = 1'b1;
        state_d        = ST_WAIT;
        ret_d          = ST_INITREF0;
        wcnt_d         = WAIT_W'(T_RP - 2);
      end
      ST_INITREF0, ST_INITREF1: begin
        cmd_d   = CMD_REF;
        state_d = ST_WAIT;
        ret_d   = (state_q == ST_INITREF0) ? ST_INITREF1 : ST_LOADMODE;
        wcnt_d  = WAIT_W'(T_RFC - 2);
      end
      ST_LOADMODE: begin
        cmd_d   = CMD_MRS;
        addr_d  = MODE_WORD;
        state_d = ST_WAIT;
        ret_d   = ST_IDLE;
        wcnt_d  = WAIT_W'(T_MRD - 2);
      end
      ST_IDLE: begin
        if (ref_pending) begin
          cmd_d      = CMD_REF;
          ref_served = 1'b1;
          state_d    = ST_WAIT;
          ret_d      = ST_IDLE;
          wcnt_d     = WAIT_W'(T_RFC - 2);
        end else if (req_valid) begin
          cmd_d   = CMD_ACT;
          ba_d    = req_bank;
          addr_d  = req_row;
          state_d = ST_WAIT;
          ret_d   = ST_COLUMN;
          wcnt_d  = WAIT_W'(T_RCD - 2);
        end
      end
      ST_COLUMN: begin
        cmd_d                 = held_q.we ? CMD_WR : CMD_RD;
        ba_d                  = held_q.bank;
        addr_d[COL_W-1:0]     = held_q.col;
        addr_d[AP_BIT]        = 1'b1;
        if (held_q.we) begin
          oe_d  = 1'b1;
          dq_d  = held_q.wdata;
          dqm_d = held_q.mask;
        end
        state_d = ST_WAIT;
        ret_d   = ST_IDLE;
        wcnt_d  = WAIT_W'(T_CLOSE - 2);
      end
      ST_WAIT: if (wcnt_q == '0) state_d = ret_q;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POWERUP;
      ret_q   <= ST_POWERUP;
      wcnt_q  <= WAIT_W'(INIT_WAIT - 1);
      held_q  <= '0;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      ba_q    <= 1'b0;
      dqm_q   <= '0;
      dq_q    <= '0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      wcnt_q  <= wcnt_d;
      if (take) held_q <= '{req_we, req_bank, req_row, req_col, req_wdata, req_mask};
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      ba_q    <= ba_d;
      dqm_q   <= dqm_d;
      dq_q    <= dq_d;
      oe_q    <= oe_d;
    end
  end

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dsf} = cmd_q;
  assign mem_addr   = addr_q;
  assign mem_ba     = ba_q;
  assign mem_dqm    = dqm_q;
  assign mem_dq_out = dq_q;
  assign mem_dq_oe  = oe_q;
endmodule

// File: rtl/sgc_chk.sv
module sgc_chk
  import sgc_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int CAS_LAT = 3,
  parameter int AP_BIT  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_cs_n,
  input logic              mem_ras_n,
  input logic              mem_cas_n,
  input logic              mem_we_n,
  input logic              mem_dsf,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);
  logic [4:0] pins;
  logic       mode_seen;

  assign pins = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dsf};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_seen <= 1'b0;
    else if (pins == CMD_MRS) mode_seen <= 1'b1;
  end

  // R2
  ready_after_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mode_seen);

  // R3
  accept_activates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (pins == CMD_ACT));

  // R4
  column_autopre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == CMD_RD || pins == CMD_WR) |-> mem_addr[AP_BIT]);

  // R6
  drive_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (pins == CMD_WR));

  // R7
  read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(pins == CMD_RD, CAS_LAT + 1));
endmodule

bind sgc_top sgc_chk #(.ADDR_W(ADDR_W), .CAS_LAT(CAS_LAT), .AP_BIT(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_cs_n  (mem_cs_n),
  .mem_ras_n (mem_ras_n),
  .mem_cas_n (mem_cas_n),
  .mem_we_n  (mem_we_n),
  .mem_dsf   (mem_dsf),
  .mem_addr  (mem_addr),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sgc_top_test.sv
module sgc_top_test;
  localparam int CL      = 3;
  localparam int INIT    = 20;
  localparam int T_RCD   = 3;
  localparam int T_RP    = 3;
  localparam int T_RFC   = 9;
  localparam int T_MRD   = 2;
  localparam int T_CLOSE = 6;
  localparam int REF_INT = 300;
  localparam int SLACK   = T_RCD + T_CLOSE + 4;

  localparam logic [4:0] C_NOP = 5'b01110;
  localparam logic [4:0] C_MRS = 5'b00000;
  localparam logic [4:0] C_ACT = 5'b00110;
  localparam logic [4:0] C_RD  = 5'b01010;
  localparam logic [4:0] C_WR  = 5'b01000;
  localparam logic [4:0] C_PRE = 5'b00100;
  localparam logic [4:0] C_REF = 5'b00010;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_we = 1'b0, req_bank = 1'b0;
  logic [9:0]  req_row = '0;
  logic [7:0]  req_col = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dsf, mem_ba, mem_dq_oe;
  logic [9:0]  mem_addr;
  logic [3:0]  mem_dqm;
  logic [31:0] mem_dq_out, mem_dq_in;

  sgc_top #(
    .CAS_LAT(CL), .INIT_WAIT(INIT), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .T_CLOSE(T_CLOSE), .REF_INTERVAL(REF_INT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .req_mask(req_mask), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_dsf(mem_dsf),
    .mem_addr(mem_addr), .mem_ba(mem_ba), .mem_dqm(mem_dqm),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  typedef struct {
    bit          we;
    bit          ba;
    logic [9:0]  row;
    logic [7:0]  col;
    logic [31:0] d;
    logic [3:0]  m;
  } breq_t;

  breq_t       acc_q[$];
  logic [31:0] exp_q[$];
  logic [31:0] shadow[int];

  // Device model and protocol checker
  logic [31:0] store[int];
  logic [31:0] rdq[CL];
  breq_t       cur;
  bit          bank_open[2];
  logic [9:0]  open_row[2];
  longint      cyc = 0, t_act = -1000, t_col = -1000, t_ref = -1000, t_pre = -1000;
  longint      t_mrs = -1000, t_opref = -1;
  int          init_step = 0, op_refs = 0, responses = 0;
  logic [4:0]  pins;
  int          key;

  assign mem_dq_in = rdq[CL-1];

  always @(posedge clk) begin
    cyc = cyc + 1;
    pins = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dsf};
    if (!rst_n) begin
      for (int i = 0; i < CL; i++) rdq[i] <= '0;
      init_step = 0;
      bank_open[0] = 1'b0;
      bank_open[1] = 1'b0;
    end else begin
      for (int i = CL - 1; i > 0; i--) rdq[i] <= rdq[i-1];
      rdq[0] <= '0;
      if (mem_dq_oe && pins != C_WR) check(1'b0, "R6", "bus driven outside write", pins, C_WR);
      if (pins != C_NOP) check(mem_dsf == 1'b0, "R9", "dsf level", mem_dsf, 0);
      case (pins)
        C_NOP: ;
        C_PRE: begin
          check(init_step == 0 && mem_addr[8], "R2", "precharge-all first", init_step, 0);
          init_step = 1;
          t_pre = cyc;
        end
        C_REF: begin
          check(bank_open[0] == 1'b0 && bank_open[1] == 1'b0, "R8", "refresh with open bank", 1, 0);
          if (init_step == 1) begin
            check(cyc - t_pre >= T_RP, "R2", "precharge to refresh gap", cyc - t_pre, T_RP);
            init_step = 2;
          end else if (init_step == 2) begin
            check(cyc - t_ref >= T_RFC, "R2", "refresh to refresh gap", cyc - t_ref, T_RFC);
            init_step = 3;
          end else begin
            check(init_step == 4, "R2", "refresh out of init order", init_step, 4);
            check(cyc - t_col >= T_CLOSE, "R5", "column to refresh gap", cyc - t_col, T_CLOSE);
            check(cyc - t_ref >= T_RFC, "R8", "refresh to refresh gap", cyc - t_ref, T_RFC);
            if (t_opref >= 0)
              check(cyc - t_opref <= REF_INT + SLACK, "R8", "refresh spacing",
                    cyc - t_opref, REF_INT + SLACK);
            t_opref = cyc;
            op_refs++;
          end
          t_ref = cyc;
        end
        C_MRS: begin
          check(init_step == 3, "R2", "mode set order", init_step, 3);
          check(mem_addr == 10'(CL << 4), "R2", "mode word", mem_addr, CL << 4);
          check(cyc - t_ref >= T_RFC, "R2", "refresh to mode gap", cyc - t_ref, T_RFC);
          init_step = 4;
          t_mrs = cyc;
        end
        C_ACT: begin
          check(init_step == 4, "R2", "activate before mode set", init_step, 4);
          check(cyc - t_mrs >= T_MRD, "R2", "mode to activate gap", cyc - t_mrs, T_MRD);
          check(cyc - t_col >= T_CLOSE, "R5", "column to activate gap", cyc - t_col, T_CLOSE);
          check(cyc - t_ref >= T_RFC, "R8", "refresh to activate gap", cyc - t_ref, T_RFC);
          check(!bank_open[mem_ba], "R3", "activate on open bank", 1, 0);
          if (acc_q.size() == 0) check(1'b0, "R3", "activate with no request", 1, 0);
          else begin
            cur = acc_q.pop_front();
            check(mem_ba == cur.ba && mem_addr == cur.row, "R3", "activate bank/row",
                  {mem_ba, mem_addr}, {cur.ba, cur.row});
          end
          bank_open[mem_ba] = 1'b1;
          open_row[mem_ba] = mem_addr;
          t_act = cyc;
        end
        C_RD, C_WR: begin
          check(cyc - t_act == T_RCD, "R4", "activate to column gap", cyc - t_act, T_RCD);
          check(mem_addr[8] == 1'b1 && mem_addr[9] == 1'b0, "R4", "auto precharge flag",
                mem_addr[9:8], 1);
          check(bank_open[mem_ba] && mem_ba == cur.ba && mem_addr[7:0] == cur.col,
                "R4", "column bank/col", {mem_ba, mem_addr[7:0]}, {cur.ba, cur.col});
          check((pins == C_WR) == cur.we, "R4", "read/write kind", pins, cur.we ? C_WR : C_RD);
          key = int'({mem_ba, open_row[mem_ba], mem_addr[7:0]});
          if (pins == C_WR) begin
            check(mem_dq_oe && mem_dq_out == cur.d && mem_dqm == cur.m, "R6",
                  "write data/mask", {mem_dqm, mem_dq_out}, {cur.m, cur.d});
            if (!store.exists(key)) store[key] = '0;
            for (int b = 0; b < 4; b++)
              if (!mem_dqm[b]) store[key][8*b +: 8] = mem_dq_out[8*b +: 8];
          end else begin
            rdq[0] <= store.exists(key) ? store[key] : '0;
          end
          bank_open[mem_ba] = 1'b0;
          t_col = cyc;
        end
        default: check(1'b0, "R9", "illegal pin code", pins, C_NOP);
      endcase
    end
  end

  // Response monitor (scoreboard)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      responses++;
      if (exp_q.size() == 0) check(1'b0, "R7", "unexpected response", rsp_data, 0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(rsp_data == e, "R7", "read data", rsp_data, e);
      end
    end
  end

  task automatic issue(input bit we, input bit ba, input logic [9:0] row,
                       input logic [7:0] col, input logic [31:0] d, input logic [3:0] m);
    breq_t r;
    int k;
    r = '{we, ba, row, col, d, m};
    k = int'({ba, row, col});
    if (!shadow.exists(k)) shadow[k] = '0;
    if (we) begin
      for (int b = 0; b < 4; b++) if (!m[b]) shadow[k][8*b +: 8] = d[8*b +: 8];
    end else exp_q.push_back(shadow[k]);
    acc_q.push_back(r);
    req_valid = 1'b1; req_we = we; req_bank = ba; req_row = row;
    req_col = col; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dsf} == C_NOP, "R1", "reset pins",
          {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dsf}, C_NOP);
    check(!req_ready && !rsp_valid && !mem_dq_oe, "R1", "reset strobes",
          {req_ready, rsp_valid, mem_dq_oe}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!req_ready && !mem_dq_oe, "R1", "idle before init", {req_ready, mem_dq_oe}, 0);
    check({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dsf} == C_NOP, "R1", "power-up wait pins",
          {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dsf}, C_NOP);
    // R3 R7: simple write and read back, both banks
    issue(1, 0, 10'd5, 8'd3, 32'h1234_5678, 4'b0000);
    issue(1, 1, 10'd5, 8'd3, 32'h8765_4321, 4'b0000);
    issue(0, 0, 10'd5, 8'd3, '0, '0);
    issue(0, 1, 10'd5, 8'd3, '0, '0);
    // R6: byte masks keep old bytes
    issue(1, 0, 10'd700, 8'd255, 32'h1122_3344, 4'b0000);
    issue(1, 0, 10'd700, 8'd255, 32'hAABB_CCDD, 4'b0101);
    issue(0, 0, 10'd700, 8'd255, '0, '0);
    issue(1, 1, 10'd1023, 8'd0, 32'hFFFF_FFFF, 4'b1111);
    issue(0, 1, 10'd1023, 8'd0, '0, '0);
    // R8 R5: back-to-back mixed traffic across refresh intervals
    for (int n = 0; n < 240; n++)
      issue($urandom_range(0, 1), $urandom_range(0, 1), 10'($urandom_range(0, 3)),
            8'($urandom_range(0, 7)), $urandom, 4'($urandom_range(0, 15)));
    repeat (700) @(negedge clk);
    repeat (CL + 4) @(negedge clk);
    check(exp_q.size() == 0, "R7", "responses outstanding", exp_q.size(), 0);
    check(acc_q.size() == 0, "R3", "requests not activated", acc_q.size(), 0);
    check(op_refs >= 6, "R8", "operational refresh count", op_refs, 6);
    check(responses > 0, "R7", "responses seen", responses, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R3", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule